// File: doc/BRIEF.md
# I2C Channel-Select Register Target

This block is the digital half of a one-of-four I2C bus switch. It listens on an upstream I2C bus as a target and holds a single control byte, whose low three bits pick which of four downstream bus segments is connected. The block samples SCL and SDA on a fast system clock and recognises START and STOP conditions. It matches its 7-bit address against a fixed upper nibble plus three strap inputs, and answers single-byte writes and reads. It drives SDA only as an open-drain pull-down enable.

A written selection is first held in a staging register. It reaches the one-hot channel enables only when the STOP condition that closes the transfer is seen. Because of this, the downstream segments are switched while every line is idle and high. On a read, the block returns the live selection in the low bits, with four per-channel interrupt flags in the upper nibble.

Top module: `i2c_chsel_target`

## Requirements
- R1: After reset the four channel enables are 0 and SDA is not pulled low. A read right after reset returns `{irq[3:0], 4'b0000}`.
- R2: The block acknowledges an address byte whose seven address bits equal `1110` followed by `strap[2:0]` (strap bit 2 first). Any other address gets no acknowledge on the address byte or on the bytes that follow, and changes nothing.
- R3: After a matching address with R/W = 0, the block acknowledges the following data byte and stages its bits 2:0.
- R4: A staged selection does not change the channel enables until a STOP condition is seen. Until then, both the enables and a readback, including a read after a repeated START, show the previous selection.
- R5: When control bit 2 is 0, all four channel enables are 0, whatever bits 1:0 hold.
- R6: When control bit 2 is 1, exactly the channel enable numbered by bits 1:0 (binary, 0 to 3) is 1.
- R7: A read shifts out the byte MSB first. Bits 7:4 carry the interrupt flags of channels 3 to 0, with bit 4 for channel 0. Bit 3 is 0. Bits 2:0 carry the applied selection.
- R8: Written bits 7:3 have no effect. They change neither the enables nor the readback.
- R9: A START condition (SDA falling while SCL is high) at any point abandons the current byte and restarts address reception. A STOP condition is SDA rising while SCL is high.
- R10: During the acknowledge slot after a read byte, SDA is not pulled low.
- R11: The interrupt flags in a read byte are captured once, at the address acknowledge. A flag change during the data bits does not alter the byte being shifted out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled level of the I2C clock line |
| sda_i | input | 1 | Sampled level of the I2C data line |
| sda_pull_o | output | 1 | When 1, SDA is pulled low (open-drain enable) |
| strap_i | input | 3 | Low three address bits from strap pins |
| irq_i | input | 4 | Per-channel interrupt pending flags, active high |
| ch_en_o | output | 4 | One-hot downstream channel enables |

## Verification
Two events can meet in one system clock: a change on an interrupt input, and the loading of the read byte at the falling SCL edge that ends the address acknowledge. The bench moves the interrupt flags in the middle of a read data byte, after that load has happened. It expects the byte on the wire to equal the snapshot taken at the acknowledge, not a mix of old and new flags. A second pairing puts a write's staged value and a readback in the same transaction through a repeated START. The bench checks that the read reports the old selection and that the enables switch only at the closing STOP.

// File: rtl/i2c_chsel_pkg.sv
package i2c_chsel_pkg;

    localparam int CTRL_W  = 8;
    localparam int NUM_CH  = 4;
    localparam int SEL_W   = $clog2(NUM_CH);
    localparam int STAGE_W = SEL_W + 1;
    localparam int CNT_W   = $clog2(CTRL_W) + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_IGNORE
    } i2c_st_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic sda_lvl_o,
    output logic start_o,
    output logic stop_o
);
    localparam int TOP = SYNC_STAGES;

    typedef struct packed {
        logic [TOP:0] scl_sh;
        logic [TOP:0] sda_sh;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.scl_sh = {sync_q.scl_sh[TOP-1:0], scl_i};
        sync_d.sda_sh = {sync_q.sda_sh[TOP-1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '{scl_sh: '1, sda_sh: '1};
        end else begin
            sync_q <= sync_d;
        end
    end

    logic scl_cur, scl_prv, sda_cur, sda_prv;
    assign scl_cur = sync_q.scl_sh[TOP-1];
    assign scl_prv = sync_q.scl_sh[TOP];
    assign sda_cur = sync_q.sda_sh[TOP-1];
    assign sda_prv = sync_q.sda_sh[TOP];

    assign scl_rise_o = scl_cur & ~scl_prv;
    assign scl_fall_o = ~scl_cur & scl_prv;
    assign sda_lvl_o  = sda_cur;
    assign start_o    = scl_cur & scl_prv & sda_prv & ~sda_cur;
    assign stop_o     = scl_cur & scl_prv & ~sda_prv & sda_cur;

    // R9
    start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_o && stop_o));

    // R9
    no_cond_on_scl_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_rise_o || scl_fall_o) |-> !(start_o || stop_o));

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import i2c_chsel_pkg::*;
#(
    parameter logic [3:0] ADDR_HI = 4'b1110
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_rise_i,
    input  logic                scl_fall_i,
    input  logic                sda_lvl_i,
    input  logic                start_i,
    input  logic                stop_i,
    input  logic [2:0]          strap_i,
    input  logic [CTRL_W-1:0]   rd_byte_i,
    output logic                sda_pull_o,
    output logic                wr_stb_o,
    output logic [STAGE_W-1:0]  wr_ctrl_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CTRL_W);

    typedef struct packed {
        i2c_st_e            state;
        logic [CNT_W-1:0]   cnt;
        logic [CTRL_W-1:0]  shreg;
        logic               rw;
        logic               pull;
        logic               wr_stb;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    logic addr_hit;
    assign addr_hit = (fsm_q.shreg[CTRL_W-1:1] == {ADDR_HI, strap_i});

    always_comb begin
        fsm_d        = fsm_q;
        fsm_d.wr_stb = 1'b0;
        if (start_i) begin
            fsm_d.state = ST_ADDR;
            fsm_d.cnt   = '0;
            fsm_d.pull  = 1'b0;
        end else if (stop_i) begin
            fsm_d.state = ST_IDLE;
            fsm_d.pull  = 1'b0;
        end else begin
            unique case (fsm_q.state)
                ST_IDLE: ;
                ST_IGNORE: fsm_d.pull = 1'b0;
                ST_ADDR: begin
                    if (scl_rise_i) begin
                        fsm_d.shreg = {fsm_q.shreg[CTRL_W-2:0], sda_lvl_i};
                        fsm_d.cnt   = fsm_q.cnt + 1'b1;
                    end else if (scl_fall_i && fsm_q.cnt == LAST_BIT) begin
                        if (addr_hit) begin
                            fsm_d.state = ST_ADDR_ACK;
                            fsm_d.pull  = 1'b1;
                            fsm_d.rw    = fsm_q.shreg[0];
                        end else begin
                            fsm_d.state = ST_IGNORE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall_i) begin
                        fsm_d.cnt = '0;
                        if (fsm_q.rw) begin
                            fsm_d.state = ST_RD_DATA;
                            fsm_d.shreg = rd_byte_i;
                            fsm_d.pull  = ~rd_byte_i[CTRL_W-1];
                        end else begin
                            fsm_d.state = ST_WR_DATA;
                            fsm_d.pull  = 1'b0;
                        end
                    end
                end
                ST_WR_DATA: begin
                    if (scl_rise_i) begin
                        fsm_d.shreg = {fsm_q.shreg[CTRL_W-2:0], sda_lvl_i};
                        fsm_d.cnt   = fsm_q.cnt + 1'b1;
                    end else if (scl_fall_i && fsm_q.cnt == LAST_BIT) begin
                        fsm_d.state  = ST_WR_ACK;
                        fsm_d.pull   = 1'b1;
                        fsm_d.wr_stb = 1'b1;
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall_i) begin
                        fsm_d.state = ST_IGNORE;
                        fsm_d.pull  = 1'b0;
                    end
                end
                ST_RD_DATA: begin
                    if (scl_rise_i) begin
                        fsm_d.cnt = fsm_q.cnt + 1'b1;
                    end else if (scl_fall_i) begin
                        if (fsm_q.cnt == LAST_BIT) begin
                            fsm_d.state = ST_RD_ACK;
                            fsm_d.pull  = 1'b0;
                        end else begin
                            fsm_d.shreg = {fsm_q.shreg[CTRL_W-2:0], 1'b0};
                            fsm_d.pull  = ~fsm_q.shreg[CTRL_W-2];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_fall_i) fsm_d.state = ST_IGNORE;
                end
                default: fsm_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{state: ST_IDLE, cnt: '0, shreg: '0, rw: 1'b0, pull: 1'b0, wr_stb: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign sda_pull_o = fsm_q.pull;
    assign wr_stb_o   = fsm_q.wr_stb;
    assign wr_ctrl_o  = fsm_q.shreg[STAGE_W-1:0];

    // R1
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_IDLE || fsm_q.state == ST_IGNORE) |=> !fsm_q.pull || start_i);

    // R2
    ack_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_ADDR_ACK) |-> (fsm_q.shreg[CTRL_W-1:1] == {ADDR_HI, strap_i}));

    // R9
    start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (fsm_q.state == ST_ADDR && fsm_q.cnt == '0 && !fsm_q.pull));

    // R10
    rd_ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_RD_ACK) |-> !fsm_q.pull);

    // R3
    wr_stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_q.wr_stb |-> (fsm_q.state == ST_WR_ACK && fsm_q.pull));

endmodule

// File: rtl/chsel_stage_reg.sv
module chsel_stage_reg
    import i2c_chsel_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_stb_i,
    input  logic [STAGE_W-1:0]  wr_ctrl_i,
    input  logic                stop_i,
    input  logic [NUM_CH-1:0]   irq_i,
    output logic [CTRL_W-1:0]   rd_byte_o,
    output logic [NUM_CH-1:0]   ch_en_o
);
    typedef struct packed {
        logic [STAGE_W-1:0] active;
        logic [STAGE_W-1:0] pend;
        logic               pend_vld;
        logic [NUM_CH-1:0]  irq_s1;
        logic [NUM_CH-1:0]  irq_s2;
    } reg_t;

    reg_t reg_d, reg_q;

    always_comb begin
        reg_d        = reg_q;
        reg_d.irq_s1 = irq_i;
        reg_d.irq_s2 = reg_q.irq_s1;
        if (wr_stb_i) begin
            reg_d.pend     = wr_ctrl_i;
            reg_d.pend_vld = 1'b1;
        end else if (stop_i && reg_q.pend_vld) begin
            reg_d.active   = reg_q.pend;
            reg_d.pend_vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    localparam int PAD_W = CTRL_W - NUM_CH - STAGE_W;
    assign rd_byte_o = {reg_q.irq_s2, {PAD_W{1'b0}}, reg_q.active};

    logic              en_bit;
    logic [SEL_W-1:0]  sel_idx;
    assign en_bit  = reg_q.active[STAGE_W-1];
    assign sel_idx = reg_q.active[SEL_W-1:0];

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_decode
        assign ch_en_o[ch] = en_bit && (sel_idx == SEL_W'(ch));
    end

    // R4
    active_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(reg_q.active) |-> $past(stop_i));

    // R6
    chen_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_en_o));

    // R5
    disabled_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_q.active[STAGE_W-1] |-> (ch_en_o == '0));

endmodule

// File: rtl/i2c_chsel_target.sv
module i2c_chsel_target
    import i2c_chsel_pkg::*;
#(
    parameter logic [3:0] ADDR_HI     = 4'b1110,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    input  logic [2:0]        strap_i,
    input  logic [NUM_CH-1:0] irq_i,
    output logic [NUM_CH-1:0] ch_en_o
);
    logic scl_rise, scl_fall, sda_lvl, start_det, stop_det;
    logic wr_stb;
    logic [STAGE_W-1:0] wr_ctrl;
    logic [CTRL_W-1:0]  rd_byte;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .sda_lvl_o  (sda_lvl),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    i2c_target_fsm #(.ADDR_HI(ADDR_HI)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .sda_lvl_i  (sda_lvl),
        .start_i    (start_det),
        .stop_i     (stop_det),
        .strap_i    (strap_i),
        .rd_byte_i  (rd_byte),
        .sda_pull_o (sda_pull_o),
        .wr_stb_o   (wr_stb),
        .wr_ctrl_o  (wr_ctrl)
    );

    chsel_stage_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb_i  (wr_stb),
        .wr_ctrl_i (wr_ctrl),
        .stop_i    (stop_det),
        .irq_i     (irq_i),
        .rd_byte_o (rd_byte),
        .ch_en_o   (ch_en_o)
    );

endmodule

// File: tb/tb_i2c_chsel_target.sv
module tb_i2c_chsel_target;

    localparam int Q = 10;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [6:0] MY_ADDR = {4'b1110, STRAP};
    localparam int NV = 8;
    // {data[7:0], irq[3:0], expected enables[3:0]}
    localparam logic [15:0] VEC [NV] = '{
        {8'h04, 4'b0000, 4'b0001},
        {8'h05, 4'b1010, 4'b0010},
        {8'h06, 4'b0101, 4'b0100},
        {8'h07, 4'b1111, 4'b1000},
        {8'h03, 4'b0011, 4'b0000},
        {8'hFD, 4'b1000, 4'b0010},
        {8'h0F, 4'b0001, 4'b1000},
        {8'h00, 4'b0000, 4'b0000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_pull;
    logic [3:0] irq = 4'b0000;
    logic [3:0] ch_en;
    logic sda_line;
    logic mid_en = 1'b0;
    logic [3:0] irq_mid = 4'b0000;
    logic ack_slot_pull;
    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    assign sda_line = m_sda & ~sda_pull;

    i2c_chsel_target dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull),
        .strap_i    (STRAP),
        .irq_i      (irq),
        .ch_en_o    (ch_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq(); wq();
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; wq();
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        b = sda_line; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic write_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b);
        acked = ~b;
    endtask

    task automatic read_byte(output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
            if (i == 5 && mid_en) irq = irq_mid;
        end
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        ack_slot_pull = sda_pull; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic do_write(input logic [7:0] v, input string req);
        logic a;
        bus_start();
        write_byte({MY_ADDR, 1'b0}, a);
        chk({req, " R2 addr ack"}, a, 1'b1);
        write_byte(v, a);
        chk({req, " R3 data ack"}, a, 1'b1);
    endtask

    task automatic do_read(output logic [7:0] v);
        logic a;
        bus_start();
        write_byte({MY_ADDR, 1'b1}, a);
        chk("R2 read addr ack", a, 1'b1);
        read_byte(v);
        chk("R10 ack slot released", ack_slot_pull, 1'b0);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] rb;
        logic [3:0] prev_en;
        logic a;

        repeat (5) @(negedge clk);
        // R1 reset state
        chk("R1 enables at reset", ch_en, 4'b0000);
        chk("R1 sda released at reset", sda_pull, 1'b0);
        rst_n = 1'b1;
        irq = 4'b1001;
        wq();
        do_read(rb);
        chk("R1 readback after reset", rb, 8'h90);

        // vector table: R3 R4 R5 R6 R7 R8
        prev_en = 4'b0000;
        for (int k = 0; k < NV; k++) begin
            irq = VEC[k][7:4];
            do_write(VEC[k][15:8], "vec");
            chk("R4 enables held before stop", ch_en, prev_en);
            bus_stop();
            chk("R5 R6 R8 enables after stop", ch_en, VEC[k][3:0]);
            do_read(rb);
            chk("R7 R8 readback", rb, {VEC[k][7:4], 1'b0, VEC[k][10:8]});
            prev_en = VEC[k][3:0];
        end

        // R2 address mismatch: no ack, no effect
        bus_start();
        write_byte({4'b1110, 3'b100, 1'b0}, a);
        chk("R2 mismatch addr no ack", a, 1'b0);
        write_byte(8'h06, a);
        chk("R2 mismatch data no ack", a, 1'b0);
        bus_stop();
        chk("R2 mismatch enables unchanged", ch_en, 4'b0000);

        // R9 aborted byte restarted by START
        bus_start();
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        do_write(8'h05, "R9 restart");
        bus_stop();
        chk("R9 write after restart applied", ch_en, 4'b0010);

        // R4 staged write, repeated START read sees old selection
        irq = 4'b0000;
        do_write(8'h07, "R4 staged");
        bus_start();
        write_byte({MY_ADDR, 1'b1}, a);
        chk("R4 repeated start read ack", a, 1'b1);
        read_byte(rb);
        chk("R4 readback still old", rb, 8'h05);
        chk("R4 enables still old", ch_en, 4'b0010);
        bus_stop();
        chk("R4 enables switch at stop", ch_en, 4'b1000);

        // R11 irq change during read bits does not alter the byte
        irq = 4'b0110;
        wq();
        irq_mid = 4'b1001;
        mid_en = 1'b1;
        do_read(rb);
        mid_en = 1'b0;
        chk("R11 snapshot of irq at ack", rb, 8'h67);
        do_read(rb);
        chk("R11 next read sees new irq", rb, 8'h97);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule